// File: doc/BRIEF.md
# Cumulative Over-Temperature Assertion Timer with Alert

This block measures how long an active-low over-temperature input has been held low in total. It adds up the low time of separate pulses in an 8-bit timer, where one timer step is worth a fixed time quantum. Software reads the timer now and then to see how much hot time has built up since the last read. The read returns the count and also clears it.

A programmable limit sets when the block raises an alert. Once the count rises above the limit, a sticky status flag is set. When the mask bit does not block it, an active-low alert output is driven. With a limit of zero, the alert comes on the very first low edge of the input, however short the pulse. An optional boost mode sends every fan that is already running to full duty while the input is low. Fans that are stopped stay stopped.

Five small registers are reached through a plain read/write port. Offset 0 is the timer (read-only, clears on read). Offset 1 is the limit. Offset 2 is the configuration. Offset 3 is the status. Offset 4 is the mask.

Top module: `therm_accum_alert`

## Requirements
- R1: While monitoring is active and the synchronized input is low, the timer rises by one for each QUANTUM_CYC low cycles. The part-quantum count is kept through high gaps, so the low time of separate pulses adds up.
- R2: The timer stops at its all-ones value (0xFF) and never wraps.
- R3: A read at offset 0 returns the timer value one cycle later on reg_rdata. The same read clears the timer and the part-quantum count to zero.
- R4: With a nonzero limit (offset 1), the status flag is set once the timer value is strictly greater than the limit. A timer equal to the limit does not set it.
- R5: With a limit of zero, the flag is set on the first high-to-low edge of the synchronized input, even when the pulse is shorter than one quantum.
- R6: The status flag (offset 3, bit 0) stays set until a read at offset 3 clears it. If the set condition holds in the same cycle as the read, the flag stays set.
- R7: When the mask (offset 4, bit 0) is 1, alert_n stays high, but the status flag is still set.
- R8: alert_n is low exactly while the status flag is 1 and the mask is 0. It returns high once the flag is cleared by a read.
- R9: Monitoring needs both configuration bit 0 (enable) and configuration bit 2 (input routing) to be 1. Otherwise the timer holds its value and the flag is not set.
- R10: With configuration bits 2 and 1 (boost) both set, each fan lane whose input duty is nonzero outputs all ones while the synchronized input is low. A zero lane stays zero. Otherwise each output lane equals its input lane.
- R11: After reset, the timer, limit, configuration, status, mask and reg_rdata are all zero, and alert_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_n | input | 1 | Asynchronous active-low over-temperature input |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data appears on the next cycle |
| reg_wdata | input | TMR_W | Write data |
| reg_rdata | output | TMR_W | Registered read data |
| alert_n | output | 1 | Active-low alert |
| fan_duty_in | input | N_FANS*DUTY_W | Requested duty per fan, lane 0 in the low bits |
| fan_duty_out | output | N_FANS*DUTY_W | Duty after the boost override |

## Verification
Several low-pulse patterns drive the input. Two short pulses separated by a gap show that the part-quantum count is kept between pulses rather than dropped. A pulse cut by a timer read shows that the read clears the prescaler. A very long pulse tells saturation apart from wrap-around. Runs with the enable or routing bit cleared show that nothing counts. For the limit, a count that lands exactly on the limit is compared against one just above it. A sub-quantum pulse with a zero limit separates edge detection from duration detection. Masked and unmasked runs, and fan lanes with zero and nonzero duty under boost, cover the output side.

// File: rtl/therm_accum_pkg.sv
package therm_accum_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_TIMER  = 3'd0,
      RA_LIMIT  = 3'd1,
      RA_CFG    = 3'd2,
      RA_STATUS = 3'd3,
      RA_MASK   = 3'd4
   } reg_addr_e;

   // configuration word, bit 0 upward: monitor enable, boost, input routing
   typedef struct packed {
      logic route;
      logic boost;
      logic mon;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/therm_sync.sv
module therm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_n,
   output logic active,
   output logic assert_edge
);
   if (STAGES < 2) begin : g_bad_stages
      $error("therm_sync: STAGES must be at least 2");
   end

   // one extra stage keeps the previous synchronized value for edge detection
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-1:0], in_n};
   end

   assign active      = ~sh_q[STAGES-1];
   assign assert_edge = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/therm_accum.sv
module therm_accum #(
   parameter int TMR_W       = 8,
   parameter int QUANTUM_CYC = 2276000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             clear,
   output logic [TMR_W-1:0] timer
);
   if (QUANTUM_CYC < 1) begin : g_bad_quantum
      $error("therm_accum: QUANTUM_CYC must be at least 1");
   end

   localparam logic [TMR_W-1:0] T_MAX = '1;

   logic tick;

   if (QUANTUM_CYC == 1) begin : g_direct
      assign tick = count_en;
   end else begin : g_prescale
      localparam int PW = $clog2(QUANTUM_CYC);
      localparam logic [PW-1:0] P_LAST = PW'(QUANTUM_CYC - 1);
      logic [PW-1:0] presc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             presc_q <= '0;
         else if (clear)         presc_q <= '0;
         else if (count_en) begin
            if (presc_q == P_LAST) presc_q <= '0;
            else                   presc_q <= presc_q + 1'b1;
         end
      end

      assign tick = count_en && (presc_q == P_LAST);
   end

   logic [TMR_W-1:0] timer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        timer_q <= '0;
      else if (clear)                    timer_q <= '0;
      else if (tick && timer_q != T_MAX) timer_q <= timer_q + 1'b1;
   end

   assign timer = timer_q;
endmodule

// File: rtl/therm_flag.sv
module therm_flag #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [TMR_W-1:0] timer,
   input  logic [TMR_W-1:0] limit,
   input  logic             first_edge,
   input  logic             clear_req,
   output logic             flag
);
   logic hit;
   logic flag_q;

   assign hit = enable && ((timer > limit) || (limit == '0 && first_edge));

   // a set in the same cycle as the clearing read wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (hit)       flag_q <= 1'b1;
      else if (clear_req) flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/fan_boost.sv
module fan_boost #(
   parameter int N_FANS = 4,
   parameter int DUTY_W = 8
) (
   input  logic                     boost_on,
   input  logic [N_FANS*DUTY_W-1:0] duty_in,
   output logic [N_FANS*DUTY_W-1:0] duty_out
);
   if (N_FANS < 1 || DUTY_W < 1) begin : g_bad_fans
      $error("fan_boost: N_FANS and DUTY_W must be positive");
   end

   localparam logic [DUTY_W-1:0] FULL = '1;

   for (genvar i = 0; i < N_FANS; i++) begin : g_lane
      logic [DUTY_W-1:0] lane;
      assign lane = duty_in[i*DUTY_W +: DUTY_W];
      assign duty_out[i*DUTY_W +: DUTY_W] = (boost_on && lane != '0) ? FULL : lane;
   end
endmodule

// File: rtl/therm_accum_alert.sv
module therm_accum_alert
   import therm_accum_pkg::*;
#(
   parameter int TMR_W       = 8,
   parameter int QUANTUM_CYC = 2276000,
   parameter int SYNC_STAGES = 2,
   parameter int N_FANS      = 4,
   parameter int DUTY_W      = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     therm_n,
   input  logic [REG_AW-1:0]        reg_addr,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [TMR_W-1:0]         reg_wdata,
   output logic [TMR_W-1:0]         reg_rdata,
   output logic                     alert_n,
   input  logic [N_FANS*DUTY_W-1:0] fan_duty_in,
   output logic [N_FANS*DUTY_W-1:0] fan_duty_out
);
   if (TMR_W < CFG_W) begin : g_bad_width
      $error("therm_accum_alert: TMR_W must hold the configuration word");
   end

   logic             therm_active;
   logic             therm_edge;
   logic             mon_gate;
   logic             timer_clr;
   logic             status_clr;
   logic [TMR_W-1:0] timer_q;
   logic [TMR_W-1:0] limit_q;
   cfg_t             cfg_q;
   logic             mask_q;
   logic             flag_q;
   logic [TMR_W-1:0] rd_mux;
   logic [TMR_W-1:0] rdata_q;

   therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_n        (therm_n),
      .active      (therm_active),
      .assert_edge (therm_edge)
   );

   assign mon_gate   = cfg_q.mon & cfg_q.route;
   assign timer_clr  = reg_rd && (reg_addr == RA_TIMER);
   assign status_clr = reg_rd && (reg_addr == RA_STATUS);

   therm_accum #(.TMR_W(TMR_W), .QUANTUM_CYC(QUANTUM_CYC)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (mon_gate & therm_active),
      .clear    (timer_clr),
      .timer    (timer_q)
   );

   therm_flag #(.TMR_W(TMR_W)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (mon_gate),
      .timer      (timer_q),
      .limit      (limit_q),
      .first_edge (therm_edge),
      .clear_req  (status_clr),
      .flag       (flag_q)
   );

   fan_boost #(.N_FANS(N_FANS), .DUTY_W(DUTY_W)) u_boost (
      .boost_on (cfg_q.boost & cfg_q.route & therm_active),
      .duty_in  (fan_duty_in),
      .duty_out (fan_duty_out)
   );

   // writable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
         cfg_q   <= '0;
         mask_q  <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_LIMIT: limit_q <= reg_wdata;
            RA_CFG:   cfg_q   <= cfg_t'(reg_wdata[CFG_W-1:0]);
            RA_MASK:  mask_q  <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         RA_TIMER:  rd_mux = timer_q;
         RA_LIMIT:  rd_mux = limit_q;
         RA_CFG:    rd_mux = {{(TMR_W-CFG_W){1'b0}}, cfg_q};
         RA_STATUS: rd_mux = {{(TMR_W-1){1'b0}}, flag_q};
         RA_MASK:   rd_mux = {{(TMR_W-1){1'b0}}, mask_q};
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;
   assign alert_n   = ~(flag_q & ~mask_q);
endmodule

// File: rtl/therm_accum_alert_chk.sv
module therm_accum_alert_chk #(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       reg_addr,
   input logic             reg_rd,
   input logic             alert_n,
   input logic [TMR_W-1:0] timer,
   input logic             flag,
   input logic             mask,
   input logic             gate
);
   logic timer_clr;
   logic flag_clr;

   assign timer_clr = reg_rd && (reg_addr == 3'd0);
   assign flag_clr  = reg_rd && (reg_addr == 3'd3);

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !timer_clr |=> (timer == $past(timer)) || (timer == $past(timer) + 1'b1)); // R1
   AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (timer == '1 && !timer_clr) |=> timer == '1); // R2
   AST_TIMER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      timer_clr |=> timer == '0); // R3
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag); // R6
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> alert_n); // R7
   AST_ALERT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_n |-> flag); // R8
   AST_NO_MON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !timer_clr) |=> $stable(timer)); // R9
endmodule

bind therm_accum_alert therm_accum_alert_chk #(.TMR_W(TMR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_rd   (reg_rd),
   .alert_n  (alert_n),
   .timer    (timer_q),
   .flag     (flag_q),
   .mask     (mask_q),
   .gate     (mon_gate)
);

// File: tb/therm_accum_alert_tb.sv
module therm_accum_alert_tb;
   localparam int Q  = 4;
   localparam int NF = 4;
   localparam int DW = 8;

   logic            clk = 0;
   logic            rst_n = 0;
   logic            therm_n = 1;
   logic [2:0]      reg_addr = 0;
   logic            reg_wr = 0;
   logic            reg_rd = 0;
   logic [7:0]      reg_wdata = 0;
   logic [7:0]      reg_rdata;
   logic            alert_n;
   logic [NF*DW-1:0] fan_duty_in = 0;
   logic [NF*DW-1:0] fan_duty_out;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   therm_accum_alert #(.TMR_W(8), .QUANTUM_CYC(Q), .SYNC_STAGES(2),
                       .N_FANS(NF), .DUTY_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .therm_n(therm_n), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .alert_n(alert_n),
      .fan_duty_in(fan_duty_in), .fan_duty_out(fan_duty_out));

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int       m_timer, m_presc, m_limit, m_cfg, m_mask, m_rdata;
   bit       m_flag;
   bit [2:0] m_sh;
   bit       g_on, g_act, g_edge, g_hit;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_timer = 0; m_presc = 0; m_limit = 0; m_cfg = 0; m_mask = 0;
         m_rdata = 0; m_flag = 0; m_sh = 3'b111;
      end else begin
         g_on   = ((m_cfg & 5) == 5);
         g_act  = g_on && !m_sh[1];
         g_edge = g_on && m_sh[2] && !m_sh[1];
         g_hit  = g_on && ((m_timer > m_limit) || (m_limit == 0 && g_edge));
         if (reg_rd) begin
            case (reg_addr)
               3'd0: m_rdata = m_timer;
               3'd1: m_rdata = m_limit;
               3'd2: m_rdata = m_cfg;
               3'd3: m_rdata = int'(m_flag);
               3'd4: m_rdata = m_mask;
               default: m_rdata = 0;
            endcase
         end
         if (reg_rd && reg_addr == 3'd0) begin
            m_timer = 0; m_presc = 0;
         end else if (g_act) begin
            m_presc = m_presc + 1;
            if (m_presc == Q) begin
               m_presc = 0;
               if (m_timer < 255) m_timer = m_timer + 1;
            end
         end
         if (g_hit) m_flag = 1;
         else if (reg_rd && reg_addr == 3'd3) m_flag = 0;
         if (reg_wr) begin
            case (reg_addr)
               3'd1: m_limit = int'(reg_wdata);
               3'd2: m_cfg = int'(reg_wdata) & 7;
               3'd4: m_mask = int'(reg_wdata) & 1;
               default: ;
            endcase
         end
         m_sh = {m_sh[1:0], therm_n};
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic [NF*DW-1:0] exp_fan;
         bit hot;
         hot = ((m_cfg & 6) == 6) && !m_sh[1];
         for (int i = 0; i < NF; i++) begin
            logic [DW-1:0] ln;
            ln = fan_duty_in[i*DW +: DW];
            exp_fan[i*DW +: DW] = (hot && ln != 0) ? '1 : ln;
         end
         check("R8 alert_n per cycle", 64'(alert_n), 64'(!(m_flag && m_mask == 0)));
         check("R3 reg_rdata per cycle", 64'(reg_rdata), 64'(m_rdata));
         check("R10 fan_duty_out per cycle", 64'(fan_duty_out), 64'(exp_fan));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [7:0] v);
      reg_rd = 1; reg_addr = a;
      @(negedge clk);
      reg_rd = 0;
      #2 v = reg_rdata;
   endtask

   task automatic pulse(int n);
      therm_n = 0;
      repeat (n) @(negedge clk);
      therm_n = 1;
      idle(4);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      // R11 reset state
      check("R11 alert_n after reset", 64'(alert_n), 64'd1);
      check("R11 rdata after reset", 64'(reg_rdata), 64'd0);
      for (int a = 0; a < 5; a++) begin
         rd_reg(3'(a), rv);
         check("R11 register reset value", 64'(rv), 64'd0);
      end

      // R9 monitoring off, then enable without routing
      pulse(20);
      rd_reg(3'd0, rv);
      check("R9 timer with cfg=0", 64'(rv), 64'd0);
      wr_reg(3'd2, 8'h01);
      pulse(20);
      rd_reg(3'd0, rv);
      check("R9 timer without routing", 64'(rv), 64'd0);
      rd_reg(3'd3, rv);
      check("R9 no flag while off", 64'(rv), 64'd0);

      // R1 accumulation across pulses
      wr_reg(3'd1, 8'hFF);
      wr_reg(3'd2, 8'h05);
      pulse(6);
      pulse(6);
      rd_reg(3'd0, rv);
      check("R1 two 6-cycle pulses", 64'(rv), 64'd3);
      rd_reg(3'd0, rv);
      check("R3 timer cleared by read", 64'(rv), 64'd0);
      pulse(3);
      rd_reg(3'd0, rv);
      pulse(3);
      rd_reg(3'd0, rv);
      check("R3 prescaler cleared by read", 64'(rv), 64'd0);

      // R2 saturation
      pulse(1100);
      rd_reg(3'd0, rv);
      check("R2 saturated timer", 64'(rv), 64'd255);
      rd_reg(3'd0, rv);
      check("R3 cleared after saturation", 64'(rv), 64'd0);

      // R4 strict greater-than compare
      wr_reg(3'd1, 8'd2);
      pulse(8);
      rd_reg(3'd3, rv);
      check("R4 timer equal to limit", 64'(rv), 64'd0);
      pulse(4);
      check("R8 alert low on flag", 64'(alert_n), 64'd0);
      rd_reg(3'd3, rv);
      check("R4 timer above limit", 64'(rv), 64'd1);
      rd_reg(3'd0, rv);
      check("R1 timer value 3", 64'(rv), 64'd3);
      rd_reg(3'd3, rv);
      check("R6 set wins over clear", 64'(rv), 64'd1);
      rd_reg(3'd3, rv);
      check("R6 cleared by read", 64'(rv), 64'd0);
      check("R8 alert high after clear", 64'(alert_n), 64'd1);

      // R5 zero limit alerts on first edge
      wr_reg(3'd1, 8'd0);
      pulse(2);
      check("R5 alert on short pulse", 64'(alert_n), 64'd0);
      rd_reg(3'd0, rv);
      check("R5 no full quantum", 64'(rv), 64'd0);
      rd_reg(3'd3, rv);
      check("R5 flag set", 64'(rv), 64'd1);
      rd_reg(3'd3, rv);
      check("R6 flag cleared", 64'(rv), 64'd0);

      // R7 mask suppresses alert only
      wr_reg(3'd4, 8'h01);
      pulse(2);
      check("R7 masked alert", 64'(alert_n), 64'd1);
      wr_reg(3'd4, 8'h00);
      check("R8 alert after unmask", 64'(alert_n), 64'd0);
      rd_reg(3'd3, rv);
      check("R7 flag set while masked", 64'(rv), 64'd1);
      rd_reg(3'd0, rv);
      rd_reg(3'd3, rv);
      check("R6 clear after masked event", 64'(rv), 64'd0);

      // R10 fan boost
      fan_duty_in = {8'h00, 8'h40, 8'h01, 8'h80};
      wr_reg(3'd1, 8'hFF);
      wr_reg(3'd2, 8'h07);
      therm_n = 0;
      idle(4);
      check("R10 boost running fans", 64'(fan_duty_out), 64'h00FFFFFF);
      therm_n = 1;
      idle(4);
      check("R10 passthrough when cool", 64'(fan_duty_out), 64'h00400180);
      wr_reg(3'd2, 8'h05);
      therm_n = 0;
      idle(4);
      check("R10 boost bit clear", 64'(fan_duty_out), 64'h00400180);
      therm_n = 1;
      idle(6);
      finish_run();
   end
endmodule